// File: doc/BRIEF.md
# Receive Buffer Status Flag Generator

This block turns the bookkeeping of a receive byte buffer into three registered status pins for a host or a neighbouring controller. The first pin says whether any byte is waiting. The second rises when the buffer fill passes a programmable level, when a complete frame is waiting, or when the buffer has overflowed. The third marks that a start-of-frame delimiter has been seen on the receive path or sent on the transmit path. It stays up until the radio leaves that direction's state.

The buffer itself lives outside the block and presents its live byte count. The block keeps three things of its own. It latches the overflow condition until a flush. It counts the complete frames held, using one pulse when a frame finishes and another when one is taken out. It holds the programmable level in a small register.

Each flag is computed from the inputs seen at a rising clock edge and is visible right after that edge. There is one register stage from any input to any flag.

Top module: `rxq_flag_gen`

## Requirements
- R1: `data_present` is high after an edge at which `byte_count` was non-zero and no overflow was in effect. It is low after an edge at which `byte_count` was zero.
- R2: While the overflow state is in effect, `data_present` is low whatever `byte_count` holds.
- R3: `level_hit` is high when `byte_count` is strictly greater than the level register, both taken as unsigned. A count equal to the level does not raise it on its own.
- R4: `level_hit` is high whenever the frame count is at least one, even if `byte_count` is at or below the level.
- R5: An `ovf_set` pulse enters the overflow state, which stays in effect until `flush`. `flush` wins over `ovf_set` in the same cycle. While the state is in effect, `level_hit` is high.
- R6: The frame count rises by one on `frame_done` and falls by one on `frame_take`. It is unchanged when both are high, never goes below zero, and saturates at its maximum. `flush` clears it to zero.
- R7: The level register is THR_W bits wide and resets to 0. It loads `thr_wdata` on `thr_we`, and the new value governs the flags from that same edge.
- R8: `sfd_rx` at an edge where `rx_on` is high sets `sfd_flag`. The flag clears at the first edge where `rx_on` is low, unless a new delimiter from the transmit side takes it over.
- R9: `sfd_tx` at an edge where `tx_on` is high sets `sfd_flag`, and it clears when `tx_on` is low. A delimiter pulse whose direction is inactive is ignored. A receive delimiter wins if both arrive together.
- R10: While `rst` is high at an edge, all three flags, the overflow state, the frame count and the level register go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| byte_count | input | CNT_W | Live number of bytes held in the receive buffer |
| thr_we | input | 1 | Write strobe for the level register |
| thr_wdata | input | THR_W | New value of the level register |
| frame_done | input | 1 | One complete frame has entered the buffer |
| frame_take | input | 1 | One complete frame has left the buffer |
| ovf_set | input | 1 | Buffer overflow occurred |
| flush | input | 1 | Buffer flushed; clears overflow and frame count |
| rx_on | input | 1 | Radio is in the receive state |
| tx_on | input | 1 | Radio is in the transmit state |
| sfd_rx | input | 1 | Delimiter received pulse |
| sfd_tx | input | 1 | Delimiter transmitted pulse |
| data_present | output | 1 | At least one byte waiting, low during overflow |
| level_hit | output | 1 | Fill above level, frame waiting, or overflow |
| sfd_flag | output | 1 | Delimiter seen in the current receive or transmit state |

## Verification
The level comparison is driven with counts one below, equal to and one above the programmed level. This separates a strict comparison from an inclusive one. Frame completion is then exercised with the count held below the level, so that the frame term alone raises the level pin. The frame count is also walked to zero and clamped there, which shows it neither underflows nor sticks. Overflow is exercised with bytes present, then held for several cycles, then cleared by a flush arriving together with a new overflow pulse; this tells latching from pulse-following and shows the flush priority. The delimiter flag is driven by receive and transmit pulses with their state both on and off, and by a direction hand-over, followed by a long stretch of mixed random stimulus.

// File: rtl/rxq_flag_pkg.sv
package rxq_flag_pkg;

    // Which direction currently owns the delimiter flag.
    typedef enum logic [1:0] {
        SFD_IDLE = 2'd0,
        SFD_RX   = 2'd1,
        SFD_TX   = 2'd2
    } sfd_owner_e;

    // The three pin-level flags as one registered word.
    typedef struct packed {
        logic present;
        logic level;
        logic sfd;
    } rxq_flags_t;

    localparam rxq_flags_t FLAGS_CLEAR = '{present: 1'b0, level: 1'b0, sfd: 1'b0};

    // Next owner of the delimiter flag. A fresh delimiter in an active
    // direction takes priority (receive first), otherwise the current
    // owner is dropped once its direction goes inactive.
    function automatic sfd_owner_e sfd_next(
        input sfd_owner_e cur,
        input logic       rx_on,
        input logic       tx_on,
        input logic       sfd_rx,
        input logic       sfd_tx
    );
        sfd_owner_e nxt;
        nxt = cur;
        if (sfd_rx && rx_on) begin
            nxt = SFD_RX;
        end else if (sfd_tx && tx_on) begin
            nxt = SFD_TX;
        end else if (cur == SFD_RX && !rx_on) begin
            nxt = SFD_IDLE;
        end else if (cur == SFD_TX && !tx_on) begin
            nxt = SFD_IDLE;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/rxq_occupancy_track.sv
module rxq_occupancy_track #(
    parameter int FRM_W = 4,
    parameter int THR_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             ovf_set,
    input  logic             frame_done,
    input  logic             frame_take,
    input  logic             thr_we,
    input  logic [THR_W-1:0] thr_wdata,
    output logic             ovf_nxt,
    output logic             frames_nxt,
    output logic [THR_W-1:0] thr_nxt
);
    localparam logic [FRM_W-1:0] FRM_MAX = {FRM_W{1'b1}};
    localparam logic [FRM_W-1:0] FRM_ONE = FRM_W'(1);

    logic             ovf_q;
    logic [FRM_W-1:0] frm_q;
    logic [FRM_W-1:0] frm_d;
    logic [THR_W-1:0] thr_q;

    always_comb begin
        ovf_nxt = flush ? 1'b0 : (ovf_q | ovf_set);
        frm_d   = frm_q;
        if (flush) begin
            frm_d = '0;
        end else if (frame_done && !frame_take) begin
            if (frm_q != FRM_MAX) frm_d = frm_q + FRM_ONE;
        end else if (frame_take && !frame_done) begin
            if (frm_q != '0) frm_d = frm_q - FRM_ONE;
        end
        thr_nxt    = thr_we ? thr_wdata : thr_q;
        frames_nxt = (frm_d != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
            frm_q <= '0;
            thr_q <= '0;
        end else begin
            ovf_q <= ovf_nxt;
            frm_q <= frm_d;
            thr_q <= thr_nxt;
        end
    end

endmodule

// File: rtl/rxq_sfd_track.sv
module rxq_sfd_track
    import rxq_flag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rx_on,
    input  logic tx_on,
    input  logic sfd_rx,
    input  logic sfd_tx,
    output logic sfd_nxt
);
    sfd_owner_e owner_q;
    sfd_owner_e owner_d;

    always_comb begin
        owner_d = sfd_next(owner_q, rx_on, tx_on, sfd_rx, sfd_tx);
        sfd_nxt = (owner_d != SFD_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) owner_q <= SFD_IDLE;
        else     owner_q <= owner_d;
    end

endmodule

// File: rtl/rxq_flag_gen.sv
module rxq_flag_gen
    import rxq_flag_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int THR_W = 7,
    parameter int FRM_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             thr_we,
    input  logic [THR_W-1:0] thr_wdata,
    input  logic             frame_done,
    input  logic             frame_take,
    input  logic             ovf_set,
    input  logic             flush,
    input  logic             rx_on,
    input  logic             tx_on,
    input  logic             sfd_rx,
    input  logic             sfd_tx,
    output logic             data_present,
    output logic             level_hit,
    output logic             sfd_flag
);
    localparam int CMP_W = ((CNT_W > THR_W) ? CNT_W : THR_W) + 1;

    logic             ovf_nxt;
    logic             frames_nxt;
    logic [THR_W-1:0] thr_nxt;
    logic             sfd_nxt;
    logic             above;
    rxq_flags_t       flags_d;
    rxq_flags_t       flags_q;

    rxq_occupancy_track #(
        .FRM_W (FRM_W),
        .THR_W (THR_W)
    ) u_occ (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .ovf_set    (ovf_set),
        .frame_done (frame_done),
        .frame_take (frame_take),
        .thr_we     (thr_we),
        .thr_wdata  (thr_wdata),
        .ovf_nxt    (ovf_nxt),
        .frames_nxt (frames_nxt),
        .thr_nxt    (thr_nxt)
    );

    rxq_sfd_track u_sfd (
        .clk     (clk),
        .rst     (rst),
        .rx_on   (rx_on),
        .tx_on   (tx_on),
        .sfd_rx  (sfd_rx),
        .sfd_tx  (sfd_tx),
        .sfd_nxt (sfd_nxt)
    );

    always_comb begin
        above           = CMP_W'(byte_count) > CMP_W'(thr_nxt);
        flags_d.present = (byte_count != '0) && !ovf_nxt;
        flags_d.level   = ovf_nxt || frames_nxt || above;
        flags_d.sfd     = sfd_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= FLAGS_CLEAR;
        else     flags_q <= flags_d;
    end

    assign data_present = flags_q.present;
    assign level_hit    = flags_q.level;
    assign sfd_flag     = flags_q.sfd;

endmodule

// File: rtl/rxq_flag_gen_chk.sv
module rxq_flag_gen_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] byte_count,
    input logic             ovf_set,
    input logic             flush,
    input logic             rx_on,
    input logic             tx_on,
    input logic             data_present,
    input logic             level_hit,
    input logic             sfd_flag
);
    // R1: a present flag needs bytes at the sampling edge
    assert_present_needs_bytes_R1: assert property (@(posedge clk) disable iff (rst)
        data_present |-> ($past(byte_count) != '0));

    // R2: an unflushed overflow pulse drops the present flag
    assert_ovf_drops_present_R2: assert property (@(posedge clk) disable iff (rst)
        (ovf_set && !flush) |=> !data_present);

    // R5: an unflushed overflow pulse raises the level flag
    assert_ovf_raises_level_R5: assert property (@(posedge clk) disable iff (rst)
        (ovf_set && !flush) |=> level_hit);

    // R8: with both directions idle the delimiter flag falls
    assert_sfd_idle_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (!rx_on && !tx_on) |=> !sfd_flag);

    // R9: a delimiter flag can only follow an active direction
    assert_sfd_needs_state_R9: assert property (@(posedge clk) disable iff (rst)
        sfd_flag |-> $past(rx_on || tx_on));

endmodule

bind rxq_flag_gen rxq_flag_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .byte_count   (byte_count),
    .ovf_set      (ovf_set),
    .flush        (flush),
    .rx_on        (rx_on),
    .tx_on        (tx_on),
    .data_present (data_present),
    .level_hit    (level_hit),
    .sfd_flag     (sfd_flag)
);

// File: tb/rxq_flag_gen_test.sv
`timescale 1ns/1ps
module rxq_flag_gen_test;
    localparam int CNT_W = 8;
    localparam int THR_W = 7;
    localparam int FRM_W = 4;
    localparam int FRM_TOP = (1 << FRM_W) - 1;

    logic             clk = 1'b0;
    logic             rst;
    logic [CNT_W-1:0] byte_count;
    logic             thr_we;
    logic [THR_W-1:0] thr_wdata;
    logic             frame_done, frame_take, ovf_set, flush;
    logic             rx_on, tx_on, sfd_rx, sfd_tx;
    logic             data_present, level_hit, sfd_flag;

    always #4 clk = ~clk;

    rxq_flag_gen #(.CNT_W(CNT_W), .THR_W(THR_W), .FRM_W(FRM_W)) uut (
        .clk(clk), .rst(rst), .byte_count(byte_count), .thr_we(thr_we),
        .thr_wdata(thr_wdata), .frame_done(frame_done), .frame_take(frame_take),
        .ovf_set(ovf_set), .flush(flush), .rx_on(rx_on), .tx_on(tx_on),
        .sfd_rx(sfd_rx), .sfd_tx(sfd_tx), .data_present(data_present),
        .level_hit(level_hit), .sfd_flag(sfd_flag)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    finished = 0;
    string tag = "R10";

    // behavioural reference state
    int m_ovf = 0, m_frm = 0, m_thr = 0, m_own = 0;
    int e_pres = 0, e_lvl = 0, e_sfd = 0;

    task automatic idle_inputs();
        byte_count = '0; thr_we = 0; thr_wdata = '0; frame_done = 0;
        frame_take = 0; ovf_set = 0; flush = 0; rx_on = 0; tx_on = 0;
        sfd_rx = 0; sfd_tx = 0;
    endtask

    task automatic predict();
        if (rst) begin
            m_ovf = 0; m_frm = 0; m_thr = 0; m_own = 0;
            e_pres = 0; e_lvl = 0; e_sfd = 0;
        end else begin
            if (flush) m_ovf = 0;
            else if (ovf_set) m_ovf = 1;
            if (flush) m_frm = 0;
            else if (frame_done && !frame_take && m_frm < FRM_TOP) m_frm++;
            else if (frame_take && !frame_done && m_frm > 0) m_frm--;
            if (thr_we) m_thr = int'(thr_wdata);
            if (sfd_rx && rx_on) m_own = 1;
            else if (sfd_tx && tx_on) m_own = 2;
            else if (m_own == 1 && !rx_on) m_own = 0;
            else if (m_own == 2 && !tx_on) m_own = 0;
            e_pres = (int'(byte_count) != 0 && m_ovf == 0) ? 1 : 0;
            e_lvl  = (m_ovf != 0 || m_frm != 0 || int'(byte_count) > m_thr) ? 1 : 0;
            e_sfd  = (m_own != 0) ? 1 : 0;
        end
    endtask

    // one clock: predict from the inputs held now, clock, then compare
    task automatic tick();
        predict();
        @(posedge clk);
        #2;
        n_vec++;
        if (int'(data_present) != e_pres || int'(level_hit) != e_lvl ||
            int'(sfd_flag) != e_sfd) begin
            n_bad++;
            $display("FAIL %s: flags present/level/sfd = %0d%0d%0d, expected %0d%0d%0d",
                     tag, data_present, level_hit, sfd_flag, e_pres, e_lvl, e_sfd);
        end
        frame_done = 0; frame_take = 0; ovf_set = 0; flush = 0;
        thr_we = 0; sfd_rx = 0; sfd_tx = 0;
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        byte_count = 8'd9;              // R10: reset must win over live inputs
        tag = "R10";
        tick(); tick();
        rst = 0;
        byte_count = '0;
        tick();

        tag = "R1";                      // present follows byte count
        byte_count = 8'd1; tick();
        byte_count = 8'd5; tick();
        byte_count = 8'd0; tick();

        tag = "R7";                      // level register write, new value used at once
        thr_we = 1; thr_wdata = 7'd10; byte_count = 8'd11; tick();
        tag = "R3";                      // strict compare around the level
        byte_count = 8'd10; tick();
        byte_count = 8'd9;  tick();
        byte_count = 8'd11; tick();
        byte_count = 8'd200; tick();     // count wider than the level field

        tag = "R4";                      // frame held with low fill
        byte_count = 8'd3;
        frame_done = 1; tick();
        tick();
        frame_done = 1; tick();
        tag = "R6";
        frame_done = 1; frame_take = 1; tick();
        frame_take = 1; tick();
        frame_take = 1; tick();          // back to zero: level drops
        frame_take = 1; tick();          // clamp at zero
        frame_done = 1; tick();          // would be zero again if it wrapped
        for (int i = 0; i < FRM_TOP + 3; i++) begin
            frame_done = 1; tick();      // saturation
        end
        flush = 1; tick();               // flush clears the frames

        tag = "R2";                      // overflow with bytes present
        byte_count = 8'd4;
        ovf_set = 1; tick();
        tag = "R5";
        tick(); tick();
        byte_count = 8'd0; tick();
        flush = 1; ovf_set = 1; tick();  // flush wins
        byte_count = 8'd2; tick();
        ovf_set = 1; tick();
        flush = 1; tick();

        tag = "R8";                      // receive delimiter
        byte_count = 8'd0;
        rx_on = 1; tick();
        sfd_rx = 1; tick();
        tick();
        rx_on = 0; tick();
        sfd_rx = 1; tick();              // ignored: receive off

        tag = "R9";                      // transmit delimiter and priority
        sfd_tx = 1; tick();              // ignored: transmit off
        tx_on = 1; sfd_tx = 1; tick();
        tick();
        rx_on = 1; tick();               // receive on, no pulse: flag stays
        tx_on = 0; sfd_rx = 1; tick();   // hand-over to receive side
        rx_on = 1; tx_on = 1; sfd_rx = 1; sfd_tx = 1; tick();
        rx_on = 0; tick();               // owner receive gone, transmit still on
        tx_on = 0; tick();

        tag = "R10";                     // mid-run reset
        byte_count = 8'd7; ovf_set = 1; tick();
        rst = 1; tick();
        rst = 0; byte_count = 8'd0; tick();

        tag = "R3";                      // mixed stimulus
        for (int i = 0; i < 600; i++) begin
            byte_count = CNT_W'($urandom_range(0, 140));
            thr_we     = ($urandom_range(0, 15) == 0);
            thr_wdata  = THR_W'($urandom_range(0, 127));
            frame_done = ($urandom_range(0, 5) == 0);
            frame_take = ($urandom_range(0, 5) == 0);
            ovf_set    = ($urandom_range(0, 30) == 0);
            flush      = ($urandom_range(0, 20) == 0);
            rx_on      = ($urandom_range(0, 3) != 0);
            tx_on      = ($urandom_range(0, 3) == 0);
            sfd_rx     = ($urandom_range(0, 6) == 0);
            sfd_tx     = ($urandom_range(0, 6) == 0);
            tick();
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule